// File: doc/BRIEF.md
# Hamming syndrome corrector

This block decodes the result of a single-error-correcting Hamming check over one 512-byte data chunk. A start pulse presents the 24-bit code that was stored alongside the chunk and the 32-bit word produced by the code generator when the chunk was read back. The generator word carries flag bits and an inverted copy of the recomputed code. The block compares the two codes in two 12-bit halves. From the result it reports whether the chunk is clean, has one flipped data bit (and which one), has one flipped bit in the stored code, or cannot be repaired.

A result is registered one cycle after start and is marked by a one-cycle done pulse. The offsets are held until the next accepted start. When the caller requests a repair and a data bit is at fault, the block performs a read-modify-write of the faulty byte through a simple byte memory port. The read returns data one cycle after the read strobe, and the write toggles exactly the faulty bit.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done, memRdEn and memWrEn are low, and status, byteOff and bitOff are zero.
- R2: A start seen while the block is idle is accepted. In the next cycle done is high for exactly one cycle, with status, byteOff and bitOff valid. These three outputs do not change until the cycle after the next accepted start.
- R3: The recomputed code is bits [23:0] of the bitwise inverse of calcWord. For each of the two codes, bits [11:0] form the low half, which is byte 0 plus the low nibble of byte 1. Bits [23:12] form the high half. The odd syndrome is the XOR of the two low halves, and the even syndrome is the XOR of the two high halves.
- R4: When both syndromes are zero, status is 0 (clean).
- R5: When the odd syndrome equals the 12-bit complement of the even syndrome, status is 1 (data bit fixed). In this case byteOff is odd[11:3] and bitOff is odd[2:0].
- R6: When exactly one bit is set across both syndromes, status is 2 (code bit fixed). For every status other than 1, byteOff and bitOff are 0.
- R7: Any other syndrome pattern gives status 3 (uncorrectable).
- R8: calcWord bit 30 is the valid flag and bit 28 is the failed flag. If bit 30 is clear or bit 28 is set, status is 3 whatever the codes are. Bit 27 has no effect on the result.
- R9: If fixEnable was high at the accepted start and status is 1, the cycle after done raises memRdEn with memAddr = byteOff. The next cycle raises memWrEn at the same address, with memWrData equal to memRdData XOR (1 << bitOff).
- R10: If fixEnable was low at start, or status is not 1, neither memRdEn nor memWrEn rises.
- R11: A start seen during the done cycle or during the read or write cycle of a repair is ignored and produces no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode of the presented codes |
| storedCode | input | 24 | Code read from spare memory |
| calcWord | input | 32 | Generator word: inverted code in [23:0], flags in [31:24] |
| fixEnable | input | 1 | Request an in-place repair of a faulty data bit |
| memRdData | input | 8 | Byte returned one cycle after memRdEn |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 clean, 1 data fixed, 2 code fixed, 3 uncorrectable |
| byteOff | output | 9 | Byte offset of the faulty data bit |
| bitOff | output | 3 | Bit offset inside that byte |
| memAddr | output | 9 | Byte address for the repair access |
| memRdEn | output | 1 | Repair read strobe |
| memWrEn | output | 1 | Repair write strobe |
| memWrData | output | 8 | Corrected byte |

## Verification
The hardest cases to reach from the ports are the data-bit pattern, where one syndrome half is the exact complement of the other, and the single-bit code error. Random codes almost never produce either. The stimulus therefore picks a syndrome of the wanted kind first (zero, complementary halves, one-hot over 24 bits, or arbitrary). It then builds the generator word as the inverse of the stored code XOR that syndrome, with the flag bits set as needed. Directed cases place the fault at byte 0 bit 0 and at byte 511 bit 7. They also raise start inside the done and repair cycles.

// File: rtl/eccfix_pkg.sv
package eccfix_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_FIX = 2'd2,
    ST_FATAL    = 2'd3
  } eccStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic rdPhase;
    logic wrPhase;
  } eccStrobe_t;

endpackage

// File: rtl/eccfix_datapath.sv
module eccfix_datapath
  import eccfix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int BYTE_W      = 8,
  parameter int CALC_W      = 32,
  parameter int VALID_BIT   = 30,
  parameter int FAILED_BIT  = 28,
  parameter bit FIX_PORT    = 1'b1,
  localparam int OFF_W      = $clog2(CHUNK_BYTES),
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int HALF_W     = OFF_W + BIT_W,
  localparam int CODE_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strb,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CALC_W-1:0] calcWord,
  input  logic              fixEnable,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byteOff,
  output logic [BIT_W-1:0]  bitOff,
  output logic              needFix,
  output logic [OFF_W-1:0]  memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData
);

  logic [CODE_W-1:0] calcCode;
  logic [HALF_W-1:0] synHalf [2];
  logic [HALF_W-1:0] oddSyn, evenSyn;
  eccStatus_e        nxtStatus, statusQ;
  logic [OFF_W-1:0]  nxtByte, byteQ;
  logic [BIT_W-1:0]  nxtBit, bitQ;
  logic              fixQ;
  logic              unusedFlags;

  assign calcCode    = ~calcWord[CODE_W-1:0];
  assign unusedFlags = ^calcWord[CALC_W-1:CODE_W];

  // half 0 = low (odd), half 1 = high (even)
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign synHalf[h] = storedCode[h*HALF_W +: HALF_W] ^ calcCode[h*HALF_W +: HALF_W];
  end
  assign oddSyn  = synHalf[0];
  assign evenSyn = synHalf[1];

  always_comb begin
    nxtStatus = ST_FATAL;
    nxtByte   = '0;
    nxtBit    = '0;
    if (!calcWord[VALID_BIT] || calcWord[FAILED_BIT]) begin
      nxtStatus = ST_FATAL;
    end else if (oddSyn == '0 && evenSyn == '0) begin
      nxtStatus = ST_CLEAN;
    end else if (oddSyn == ~evenSyn) begin
      nxtStatus = ST_DATA_FIX;
      nxtByte   = oddSyn[HALF_W-1:BIT_W];
      nxtBit    = oddSyn[BIT_W-1:0];
    end else if ($onehot({evenSyn, oddSyn})) begin
      nxtStatus = ST_CODE_FIX;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      byteQ   <= '0;
      bitQ    <= '0;
      fixQ    <= 1'b0;
    end else if (strb.capture) begin
      statusQ <= nxtStatus;
      byteQ   <= nxtByte;
      bitQ    <= nxtBit;
      fixQ    <= fixEnable;
    end
  end

  assign status  = statusQ;
  assign byteOff = byteQ;
  assign bitOff  = bitQ;

  if (FIX_PORT) begin : g_fix
    logic [BYTE_W-1:0] fixMask;
    logic              unusedCap;
    assign unusedCap = strb.capture ^ unusedFlags;
    assign fixMask   = BYTE_W'(1) << bitQ;
    assign needFix   = fixQ && (statusQ == ST_DATA_FIX);
    assign memAddr   = byteQ;
    assign memRdEn   = strb.rdPhase;
    assign memWrEn   = strb.wrPhase;
    assign memWrData = memRdData ^ fixMask;
  end else begin : g_nofix
    logic unusedPort;
    assign unusedPort = ^{memRdData, strb, fixQ, unusedFlags};
    assign needFix    = 1'b0;
    assign memAddr    = '0;
    assign memRdEn    = 1'b0;
    assign memWrEn    = 1'b0;
    assign memWrData  = '0;
  end

endmodule

// File: rtl/eccfix_ctrl.sv
module eccfix_ctrl
  import eccfix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       needFix,
  output eccStrobe_t strb,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_REPORT, S_READ, S_WRITE} ctrlState_e;
  ctrlState_e state, nxtState;

  always_comb begin
    nxtState = state;
    unique case (state)
      S_IDLE:   if (start) nxtState = S_REPORT;
      S_REPORT: nxtState = needFix ? S_READ : S_IDLE;
      S_READ:   nxtState = S_WRITE;
      S_WRITE:  nxtState = S_IDLE;
      default:  nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

  assign strb.capture = (state == S_IDLE) && start;
  assign strb.rdPhase = (state == S_READ);
  assign strb.wrPhase = (state == S_WRITE);
  assign done         = (state == S_REPORT);

endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import eccfix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int BYTE_W      = 8,
  parameter int CALC_W      = 32,
  parameter int VALID_BIT   = 30,
  parameter int FAILED_BIT  = 28,
  parameter bit FIX_PORT    = 1'b1,
  localparam int OFF_W      = $clog2(CHUNK_BYTES),
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int CODE_W     = 2 * (OFF_W + BIT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CALC_W-1:0] calcWord,
  input  logic              fixEnable,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              done,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byteOff,
  output logic [BIT_W-1:0]  bitOff,
  output logic [OFF_W-1:0]  memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData
);

  eccStrobe_t strb;
  logic       needFix;

  eccfix_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .needFix (needFix),
    .strb    (strb),
    .done    (done)
  );

  eccfix_datapath #(
    .CHUNK_BYTES (CHUNK_BYTES),
    .BYTE_W      (BYTE_W),
    .CALC_W      (CALC_W),
    .VALID_BIT   (VALID_BIT),
    .FAILED_BIT  (FAILED_BIT),
    .FIX_PORT    (FIX_PORT)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .storedCode (storedCode),
    .calcWord   (calcWord),
    .fixEnable  (fixEnable),
    .memRdData  (memRdData),
    .status     (status),
    .byteOff    (byteOff),
    .bitOff     (bitOff),
    .needFix    (needFix),
    .memAddr    (memAddr),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn),
    .memWrData  (memWrData)
  );

endmodule

// File: rtl/ecc_syndrome_fix_chk.sv
module ecc_syndrome_fix_chk #(
  parameter int OFF_W  = 9,
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic [1:0]        status,
  input logic [OFF_W-1:0]  byteOff,
  input logic [BIT_W-1:0]  bitOff,
  input logic [OFF_W-1:0]  memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [BYTE_W-1:0] memRdData,
  input logic [BYTE_W-1:0] memWrData
);

  assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  assert_result_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(status) && $stable(byteOff) && $stable(bitOff)));

  assert_single_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_offsets_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && status != 2'd1) |-> (byteOff == '0 && bitOff == '0));

  assert_read_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ($past(done) && memAddr == byteOff));

  assert_write_follows_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (memWrEn && $stable(memAddr)));

  assert_one_bit_toggled_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($countones(memWrData ^ memRdData) == 1));

  assert_no_access_unless_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (status == 2'd1));

endmodule

bind ecc_syndrome_fix ecc_syndrome_fix_chk #(
  .OFF_W  (OFF_W),
  .BIT_W  (BIT_W),
  .BYTE_W (BYTE_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .done      (done),
  .status    (status),
  .byteOff   (byteOff),
  .bitOff    (bitOff),
  .memAddr   (memAddr),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .memRdData (memRdData),
  .memWrData (memWrData)
);

// File: tb/ecc_syndrome_fix_tb_top.sv
module ecc_syndrome_fix_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] storedCode = '0;
  logic [31:0] calcWord = '0;
  logic        fixEnable = 1'b0;
  logic [7:0]  memRdData = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byteOff;
  logic [2:0]  bitOff;
  logic [8:0]  memAddr;
  logic        memRdEn, memWrEn;
  logic [7:0]  memWrData;

  int vectors = 0;
  int miscompares = 0;

  always #2.5ns clk = ~clk;

  ecc_syndrome_fix dut_i (
    .clk(clk), .rstN(rstN), .start(start), .storedCode(storedCode),
    .calcWord(calcWord), .fixEnable(fixEnable), .memRdData(memRdData),
    .done(done), .status(status), .byteOff(byteOff), .bitOff(bitOff),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference decode, byte-oriented: returns {status, byte, bit}
  function automatic logic [13:0] refDecode(input logic [23:0] st, input logic [31:0] cw);
    logic [31:0] inv;
    int s0, s1, s2, c0, c1, c2, sLo, sHi, cLo, cHi, odd, even;
    inv = ~cw;
    s0 = int'(st[7:0]);   s1 = int'(st[15:8]);   s2 = int'(st[23:16]);
    c0 = int'(inv[7:0]);  c1 = int'(inv[15:8]);  c2 = int'(inv[23:16]);
    sLo = (s0 | (s1 << 8)) & 'hFFF;  sHi = ((s1 >> 4) | (s2 << 4)) & 'hFFF;
    cLo = (c0 | (c1 << 8)) & 'hFFF;  cHi = ((c1 >> 4) | (c2 << 4)) & 'hFFF;
    odd = sLo ^ cLo;
    even = sHi ^ cHi;
    if (!cw[30] || cw[28]) return {2'd3, 12'd0};
    if (odd == 0 && even == 0) return {2'd0, 12'd0};
    if (odd == (~even & 'hFFF)) return {2'd1, 9'((odd >> 3) & 'h1FF), 3'(odd & 7)};
    if ($countones(32'(odd | even)) == 1) return {2'd2, 12'd0};
    return {2'd3, 12'd0};
  endfunction

  // generator word whose syndrome against st is syn (odd in [11:0], even in [23:12])
  function automatic logic [31:0] buildCalc(input logic [23:0] st, input logic [23:0] syn,
                                            input logic [7:0] flags);
    return {flags, ~(st ^ syn)};
  endfunction

  // mode: 0 plain, 1 start held through done cycle, 2 start during repair read
  task automatic runCase(input logic [23:0] st, input logic [31:0] cw, input bit fix,
                         input logic [7:0] rdByte, input int mode);
    logic [13:0] exp;
    bit          expFix;
    exp    = refDecode(st, cw);
    expFix = fix && (exp[13:12] == 2'd1);
    @(negedge clk);
    storedCode = st; calcWord = cw; fixEnable = fix; start = 1'b1;
    @(negedge clk);
    if (mode != 1) start = 1'b0;
    check(done == 1'b1, "R2 done", 32'(done), 1);
    check(status == exp[13:12], "R3-class status (R4 R5 R6 R7 R8)", 32'(status), 32'(exp[13:12]));
    check(byteOff == exp[11:3], "R5 byteOff", 32'(byteOff), 32'(exp[11:3]));
    check(bitOff == exp[2:0], "R5 bitOff", 32'(bitOff), 32'(exp[2:0]));
    @(negedge clk);
    start = 1'b0;
    if (expFix) begin
      check(memRdEn == 1'b1 && memWrEn == 1'b0, "R9 read strobe", {memRdEn, memWrEn}, 2'b10);
      check(memAddr == exp[11:3], "R9 read address", 32'(memAddr), 32'(exp[11:3]));
      memRdData = rdByte;
      if (mode == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(memWrEn == 1'b1 && memRdEn == 1'b0, "R9 write strobe", {memRdEn, memWrEn}, 2'b01);
      check(memWrData == (rdByte ^ (8'd1 << exp[2:0])), "R9 write data", 32'(memWrData),
            32'(rdByte ^ (8'd1 << exp[2:0])));
      check(done == 1'b0, "R11 no done during repair", 32'(done), 0);
      @(negedge clk);
      check(done == 1'b0 && memWrEn == 1'b0, "R11 no done after repair", {done, memWrEn}, 0);
    end else begin
      check(memRdEn == 1'b0 && memWrEn == 1'b0, "R10 no access", {memRdEn, memWrEn}, 0);
      check(done == 1'b0, "R11 single done", 32'(done), 0);
      if (mode == 1) begin
        @(negedge clk);
        check(done == 1'b0, "R11 start in done cycle ignored", 32'(done), 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && memRdEn == 1'b0 && memWrEn == 1'b0, "R1 strobes in reset",
          {done, memRdEn, memWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(status == 2'd0 && byteOff == '0 && bitOff == '0 && !done, "R1 after reset",
          {status, byteOff, bitOff, done}, 0);

    // directed corners
    runCase(24'hA5C33C, buildCalc(24'hA5C33C, 24'h0, 8'h40), 1'b1, 8'h00, 0);          // R4
    runCase(24'h123456, buildCalc(24'h123456, {12'hFFF, 12'h000}, 8'h40), 1'b1, 8'hFF, 0); // R5 byte0 bit0
    runCase(24'h0F0F0F, buildCalc(24'h0F0F0F, {12'h000, 12'hFFF}, 8'h40), 1'b1, 8'h3C, 0); // R5 byte511 bit7
    runCase(24'h777777, buildCalc(24'h777777, {12'hC35, 12'h3CA}, 8'h40), 1'b0, 8'h11, 0); // R10 fix off
    runCase(24'h246800, buildCalc(24'h246800, 24'h000001, 8'h40), 1'b1, 8'h5A, 0);     // R6 low bit
    runCase(24'h246800, buildCalc(24'h246800, 24'h800000, 8'h40), 1'b1, 8'h5A, 0);     // R6 high bit
    runCase(24'hFFFFFF, buildCalc(24'hFFFFFF, 24'h000003, 8'h40), 1'b1, 8'h5A, 0);     // R7
    runCase(24'h13579B, buildCalc(24'h13579B, 24'h0, 8'h00), 1'b1, 8'h5A, 0);          // R8 not valid
    runCase(24'h13579B, buildCalc(24'h13579B, {12'h0F0, 12'hF0F}, 8'h50), 1'b1, 8'h5A, 0); // R8 failed
    runCase(24'h13579B, buildCalc(24'h13579B, 24'h0, 8'h48), 1'b1, 8'h5A, 0);          // R8 bit27 no effect
    runCase(24'hABCDEF, buildCalc(24'hABCDEF, 24'h0, 8'h40), 1'b0, 8'h00, 1);          // R11 in done cycle
    runCase(24'h55AA55, buildCalc(24'h55AA55, {12'h9A6, 12'h659}, 8'h40), 1'b1, 8'h81, 2); // R11 in repair

    // constrained random: choose the syndrome kind first (R3)
    for (int n = 0; n < 400; n++) begin
      logic [23:0] st, syn;
      logic [11:0] odd;
      logic [7:0]  flags;
      int          kind;
      st    = 24'($urandom);
      kind  = int'($urandom_range(0, 4));
      odd   = 12'($urandom);
      flags = (8'($urandom) & 8'hAF) | 8'h40;
      case (kind)
        0:       syn = 24'h0;
        1, 2:    syn = {~odd, odd};
        3:       syn = 24'h1 << $urandom_range(0, 23);
        default: syn = 24'($urandom);
      endcase
      if ($urandom_range(0, 15) == 0) flags = flags ^ 8'h40;
      if ($urandom_range(0, 15) == 0) flags = flags | 8'h10;
      runCase(st, buildCalc(st, syn, flags), 1'($urandom), 8'($urandom), int'($urandom_range(0, 2)));
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule